// File: doc/BRIEF.md
# Integer Execution Unit with Overflow Trap

This block is the combinational integer datapath of a 32-bit processor core. Each cycle it receives the two register operands (`opa` is the first source register, `opb` the second), a 16-bit immediate field, a 5-bit constant shift count, the destination register index and an operation code. It returns the computed value, a write-enable for the register file and a signed-overflow flag. The operations covered are:

- add and subtract, each with and without an overflow trap;
- AND, OR, XOR and NOR;
- immediate forms of add, AND, OR and XOR;
- loading an immediate into the upper half of the result;
- signed and unsigned set-on-less-than, in register and immediate forms;
- left, logical-right and arithmetic-right shifts, by a constant or by an amount taken from a register.

On a signed overflow of a trapping operation, the write-enable drops so that the destination register keeps its old contents. Writes aimed at index 0 are always suppressed.

Top module: `int_exec_unit`

## Requirements
- R1: For the trapping ops (`OP_ADD`, `OP_ADDI`, `OP_SUB`), `ovf` is 1 exactly when the two's-complement result does not fit in 32 bits. In that case `wr_en` is 0. `result` still carries the wrapped 32-bit value.
- R2: The non-trapping ops (`OP_ADDU`, `OP_ADDIU`, `OP_SUBU`) give the wrapped sum or difference and never raise `ovf`. No other operation raises `ovf` either.
- R3: `OP_ANDI`, `OP_ORI` and `OP_XORI` combine `opa` with the immediate zero-extended to 32 bits.
- R4: `OP_ADDI`, `OP_ADDIU`, `OP_SLTI` and `OP_SLTIU` use the immediate sign-extended from its bit 15.
- R5: `OP_LUI` returns the immediate in bits 31..16 and zeros in bits 15..0.
- R6: `OP_SLT` and `OP_SLTI` return 1 when `opa` is less than the second operand as signed numbers, and 0 otherwise.
- R7: `OP_SLTU` and `OP_SLTIU` return 1 when `opa` is less than the second operand as unsigned numbers, and 0 otherwise. For `OP_SLTIU` the immediate is sign-extended first.
- R8: `OP_SLL`, `OP_SRL` and `OP_SRA` shift `opb` by `shamt`. `OP_SRA` fills vacated bits with `opb[31]`; the other two fill with zeros.
- R9: `OP_SLLV`, `OP_SRLV` and `OP_SRAV` shift `opb` by `opa[4:0]`. The upper bits of `opa` are ignored.
- R10: `OP_AND`, `OP_OR`, `OP_XOR` and `OP_NOR` combine `opa` and `opb` bitwise. `OP_NOR` returns ~(`opa` | `opb`).
- R11: When `dst_idx` is 0, `wr_en` is 0 whatever the operation.
- R12: When `dst_idx` is not 0 and `ovf` is 0, `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code; values are those of `alu_pkg::op_e` |
| opa | input | 32 | First source register value (also the variable shift amount) |
| opb | input | 32 | Second source register value (also the shifted value) |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift count |
| dst_idx | input | 5 | Destination register index |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Register-file write enable |
| ovf | output | 1 | Signed overflow on a trapping operation |

## Verification
The assertions assume that all inputs are stable, known values whenever they are evaluated. They also assume that `op_sel` holds one of the 24 defined codes, since the checks on comparison and upper-immediate results key on those codes. The stimulus only ever draws `op_sel` from 0 to 23. It changes inputs on the falling clock edge only, so every check sees a settled set of operands. Operand values are random, mixed with chosen extremes (the most negative value, all-ones, the sign boundary of the immediate) that drive overflow and the sign-sensitive paths.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN = 32;
    localparam int IMMW = 16;
    localparam int SHW  = $clog2(XLEN);

    typedef enum logic [4:0] {
        OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
        OP_AND, OP_OR, OP_XOR, OP_NOR,
        OP_ADDI, OP_ADDIU, OP_ANDI, OP_ORI, OP_XORI, OP_LUI,
        OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU,
        OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV
    } op_e;

    typedef enum logic [1:0] {U_ARITH, U_LOGIC, U_SHIFT, U_CMP} unit_e;
    typedef enum logic [2:0] {LG_AND, LG_OR, LG_XOR, LG_NOR, LG_PASSB} lg_e;
    typedef enum logic [1:0] {SH_LL, SH_RL, SH_RA} sh_e;
    typedef enum logic [1:0] {IMM_NONE, IMM_SEXT, IMM_ZEXT, IMM_UPPER} imm_e;

    typedef struct packed {
        unit_e unit;
        imm_e  imm;
        logic  sub;
        logic  ovf_chk;
        logic  cmp_uns;
        lg_e   lg;
        sh_e   sh;
        logic  sh_var;
    } ctl_t;

    function automatic ctl_t decode(op_e op);
        ctl_t c;
        c.unit    = U_ARITH;
        c.imm     = IMM_NONE;
        c.sub     = 1'b0;
        c.ovf_chk = 1'b0;
        c.cmp_uns = 1'b0;
        c.lg      = LG_AND;
        c.sh      = SH_LL;
        c.sh_var  = 1'b0;
        case (op)
            OP_ADD:   c.ovf_chk = 1'b1;
            OP_ADDU:  ;
            OP_SUB:   begin c.sub = 1'b1; c.ovf_chk = 1'b1; end
            OP_SUBU:  c.sub = 1'b1;
            OP_AND:   begin c.unit = U_LOGIC; c.lg = LG_AND; end
            OP_OR:    begin c.unit = U_LOGIC; c.lg = LG_OR;  end
            OP_XOR:   begin c.unit = U_LOGIC; c.lg = LG_XOR; end
            OP_NOR:   begin c.unit = U_LOGIC; c.lg = LG_NOR; end
            OP_ADDI:  begin c.imm = IMM_SEXT; c.ovf_chk = 1'b1; end
            OP_ADDIU: c.imm = IMM_SEXT;
            OP_ANDI:  begin c.unit = U_LOGIC; c.lg = LG_AND; c.imm = IMM_ZEXT; end
            OP_ORI:   begin c.unit = U_LOGIC; c.lg = LG_OR;  c.imm = IMM_ZEXT; end
            OP_XORI:  begin c.unit = U_LOGIC; c.lg = LG_XOR; c.imm = IMM_ZEXT; end
            OP_LUI:   begin c.unit = U_LOGIC; c.lg = LG_PASSB; c.imm = IMM_UPPER; end
            OP_SLT:   begin c.unit = U_CMP; c.sub = 1'b1; end
            OP_SLTU:  begin c.unit = U_CMP; c.sub = 1'b1; c.cmp_uns = 1'b1; end
            OP_SLTI:  begin c.unit = U_CMP; c.sub = 1'b1; c.imm = IMM_SEXT; end
            OP_SLTIU: begin c.unit = U_CMP; c.sub = 1'b1; c.cmp_uns = 1'b1; c.imm = IMM_SEXT; end
            OP_SLL:   begin c.unit = U_SHIFT; c.sh = SH_LL; end
            OP_SRL:   begin c.unit = U_SHIFT; c.sh = SH_RL; end
            OP_SRA:   begin c.unit = U_SHIFT; c.sh = SH_RA; end
            OP_SLLV:  begin c.unit = U_SHIFT; c.sh = SH_LL; c.sh_var = 1'b1; end
            OP_SRLV:  begin c.unit = U_SHIFT; c.sh = SH_RL; c.sh_var = 1'b1; end
            OP_SRAV:  begin c.unit = U_SHIFT; c.sh = SH_RA; c.sh_var = 1'b1; end
            default:  ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/operand_prep.sv
module operand_prep
    import alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMMW,
    parameter int SW = SHW
) (
    input  ctl_t          ctl,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [IW-1:0] imm,
    input  logic [SW-1:0] shamt,
    output logic [W-1:0]  b_eff,
    output logic [SW-1:0] sh_amt
);
    localparam int PADW = W - IW;

    always_comb begin
        case (ctl.imm)
            IMM_SEXT:  b_eff = {{PADW{imm[IW-1]}}, imm};
            IMM_ZEXT:  b_eff = {{PADW{1'b0}}, imm};
            IMM_UPPER: b_eff = {imm, {PADW{1'b0}}};
            default:   b_eff = opb;
        endcase
        sh_amt = ctl.sh_var ? opa[SW-1:0] : shamt;
    end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cmp_uns,
    output logic [W-1:0] sum,
    output logic         ovf_raw,
    output logic         lt
);
    logic [W-1:0] b_op;
    logic [W:0]   wide;

    always_comb begin
        b_op    = sub ? ~b : b;
        wide    = {1'b0, a} + {1'b0, b_op} + {{W{1'b0}}, sub};
        sum     = wide[W-1:0];
        ovf_raw = (a[W-1] == b_op[W-1]) && (sum[W-1] != a[W-1]);
        if (cmp_uns)
            lt = ~wide[W];
        else
            lt = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];
    end
endmodule

// File: rtl/logic_unit.sv
module logic_unit
    import alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  lg_e          fn,
    output logic [W-1:0] y
);
    always_comb begin
        case (fn)
            LG_AND:   y = a & b;
            LG_OR:    y = a | b;
            LG_XOR:   y = a ^ b;
            LG_NOR:   y = ~(a | b);
            default:  y = b;
        endcase
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int SW = SHW
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] amt,
    input  sh_e           kind,
    output logic [W-1:0]  y
);
    logic [W-1:0] stage [SW+1];
    logic         fill;
    logic         left;

    assign fill     = (kind == SH_RA) ? val[W-1] : 1'b0;
    assign left     = (kind == SH_LL);
    assign stage[0] = val;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int D = 1 << s;
        always_comb begin
            if (!amt[s])
                stage[s+1] = stage[s];
            else if (left)
                stage[s+1] = {stage[s][W-1-D:0], {D{1'b0}}};
            else
                stage[s+1] = {{D{fill}}, stage[s][W-1:D]};
        end
    end

    assign y = stage[SW];
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMMW,
    parameter int SW = SHW,
    parameter int RW = 5
) (
    input  logic [4:0]    op_sel,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [IW-1:0] imm16,
    input  logic [SW-1:0] shamt,
    input  logic [RW-1:0] dst_idx,
    output logic [W-1:0]  result,
    output logic          wr_en,
    output logic          ovf
);
    op_e          op;
    ctl_t         ctl;
    logic [W-1:0] b_eff;
    logic [SW-1:0] sh_amt;
    logic [W-1:0] sum, lg_y, sh_y;
    logic         ovf_raw, lt;

    assign op  = op_e'(op_sel);
    assign ctl = decode(op);

    operand_prep #(.W(W), .IW(IW), .SW(SW)) u_prep (
        .ctl(ctl), .opa(opa), .opb(opb), .imm(imm16), .shamt(shamt),
        .b_eff(b_eff), .sh_amt(sh_amt)
    );

    addsub_unit #(.W(W)) u_add (
        .a(opa), .b(b_eff), .sub(ctl.sub), .cmp_uns(ctl.cmp_uns),
        .sum(sum), .ovf_raw(ovf_raw), .lt(lt)
    );

    logic_unit #(.W(W)) u_logic (
        .a(opa), .b(b_eff), .fn(ctl.lg), .y(lg_y)
    );

    shift_unit #(.W(W), .SW(SW)) u_shift (
        .val(opb), .amt(sh_amt), .kind(ctl.sh), .y(sh_y)
    );

    always_comb begin
        case (ctl.unit)
            U_LOGIC: result = lg_y;
            U_SHIFT: result = sh_y;
            U_CMP:   result = {{(W-1){1'b0}}, lt};
            default: result = sum;
        endcase
        ovf   = ctl.ovf_chk & ovf_raw;
        wr_en = (dst_idx != '0) & ~ovf;
    end

    always_comb begin
        // R1
        ovf_blocks_write_chk: assert (!(ovf && wr_en))
            else $error("write enabled during overflow");
        // R2
        no_overflow_chk: assert (!(ovf && !(op == OP_ADD || op == OP_ADDI || op == OP_SUB)))
            else $error("overflow on non-trapping op");
        // R11
        zero_dst_chk: assert (!(dst_idx == '0 && wr_en))
            else $error("write to index zero");
        // R6 R7
        cmp_bool_chk: assert (!((op == OP_SLT || op == OP_SLTU || op == OP_SLTI || op == OP_SLTIU)
                                && result[W-1:1] != '0))
            else $error("compare result not boolean");
        // R5
        upper_low_zero_chk: assert (!(op == OP_LUI && result[W-IW-1:0] != '0))
            else $error("upper-immediate low half not zero");
        // R12
        write_when_clean_chk: assert (!(dst_idx != '0 && !ovf && !wr_en))
            else $error("write dropped without overflow");
    end
endmodule

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;
    import alu_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [4:0]  op_sel;
    logic [31:0] opa, opb;
    logic [15:0] imm16;
    logic [4:0]  shamt, dst_idx;
    logic [31:0] result;
    logic        wr_en, ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_exec_unit dut (
        .op_sel(op_sel), .opa(opa), .opb(opb), .imm16(imm16),
        .shamt(shamt), .dst_idx(dst_idx),
        .result(result), .wr_en(wr_en), .ovf(ovf)
    );

    function automatic string req_of(op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_ADDI:                    return "R1";
            OP_ADDU, OP_SUBU, OP_ADDIU:                 return "R2";
            OP_ANDI, OP_ORI, OP_XORI:                   return "R3";
            OP_LUI:                                     return "R5";
            OP_SLT, OP_SLTI:                            return "R6";
            OP_SLTU, OP_SLTIU:                          return "R7";
            OP_SLL, OP_SRL, OP_SRA:                     return "R8";
            OP_SLLV, OP_SRLV, OP_SRAV:                  return "R9";
            default:                                    return "R10";
        endcase
    endfunction

    function automatic logic [33:0] model(op_e op, logic [31:0] a, logic [31:0] b,
                                          logic [15:0] im, logic [4:0] sa, logic [4:0] d);
        logic [31:0] sx, zx, r;
        logic [32:0] w;
        logic        v;
        logic [4:0]  n;
        sx = {{16{im[15]}}, im};
        zx = {16'h0, im};
        v  = 1'b0;
        r  = '0;
        n  = (op == OP_SLLV || op == OP_SRLV || op == OP_SRAV) ? a[4:0] : sa;
        case (op)
            OP_ADD:   begin w = {a[31], a} + {b[31], b};   r = w[31:0]; v = w[32] ^ w[31]; end
            OP_ADDI:  begin w = {a[31], a} + {sx[31], sx}; r = w[31:0]; v = w[32] ^ w[31]; end
            OP_SUB:   begin w = {a[31], a} - {b[31], b};   r = w[31:0]; v = w[32] ^ w[31]; end
            OP_ADDU:  r = a + b;
            OP_ADDIU: r = a + sx;
            OP_SUBU:  r = a - b;
            OP_AND:   r = a & b;
            OP_OR:    r = a | b;
            OP_XOR:   r = a ^ b;
            OP_NOR:   r = ~(a | b);
            OP_ANDI:  r = a & zx;
            OP_ORI:   r = a | zx;
            OP_XORI:  r = a ^ zx;
            OP_LUI:   r = {im, 16'h0};
            OP_SLT:   r = {31'h0, $signed(a) < $signed(b)};
            OP_SLTI:  r = {31'h0, $signed(a) < $signed(sx)};
            OP_SLTU:  r = {31'h0, a < b};
            OP_SLTIU: r = {31'h0, a < sx};
            OP_SLL, OP_SLLV: r = b << n;
            OP_SRL, OP_SRLV: r = b >> n;
            OP_SRA, OP_SRAV: r = 32'($signed(b) >>> n);
            default:  r = '0;
        endcase
        return {r, (d != 0) && !v, v};
    endfunction

    task automatic apply(string tag, op_e op, logic [31:0] a, logic [31:0] b,
                         logic [15:0] im, logic [4:0] sa, logic [4:0] d);
        logic [33:0] exp;
        @(negedge clk);
        op_sel = op; opa = a; opb = b; imm16 = im; shamt = sa; dst_idx = d;
        exp = model(op, a, b, im, sa, d);
        @(posedge clk);
        #(CLK_PERIOD/4);
        n_checks++;
        if ({result, wr_en, ovf} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%s: got result=%h wr_en=%b ovf=%b, expected result=%h wr_en=%b ovf=%b",
                     tag, op.name(), result, wr_en, ovf, exp[33:2], exp[1], exp[0]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        op_sel = '0; opa = '0; opb = '0; imm16 = '0; shamt = '0; dst_idx = '0;
        // idle inputs: all zero, index 0
        apply("R11", OP_ADD, 32'h0, 32'h0, 16'h0, 5'd0, 5'd0);
        // R1 overflow cases
        apply("R1", OP_ADD,  32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 5'd3);
        apply("R1", OP_SUB,  32'h8000_0000, 32'h1, 16'h0, 5'd0, 5'd3);
        apply("R1", OP_ADDI, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0, 5'd3);
        apply("R1", OP_ADD,  32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 5'd3);
        // R2 same operands, no trap
        apply("R2", OP_ADDU,  32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 5'd3);
        apply("R2", OP_SUBU,  32'h8000_0000, 32'h1, 16'h0, 5'd0, 5'd3);
        apply("R2", OP_ADDIU, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0, 5'd3);
        // R3 zero extension of immediate with bit 15 set
        apply("R3", OP_ORI,  32'h0, 32'h0, 16'h8001, 5'd0, 5'd4);
        apply("R3", OP_ANDI, 32'hFFFF_FFFF, 32'h0, 16'hF0F0, 5'd0, 5'd4);
        // R4 sign extension
        apply("R4", OP_ADDIU, 32'h10, 32'h0, 16'hFFFF, 5'd0, 5'd4);
        // R5
        apply("R5", OP_LUI, 32'hDEAD_BEEF, 32'h0, 16'hA5C3, 5'd0, 5'd5);
        // R6 signed compare
        apply("R6", OP_SLT,  32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 5'd6);
        apply("R6", OP_SLTI, 32'h5, 32'h0, 16'hFFFF, 5'd0, 5'd6);
        // R7 unsigned compare with sign-extended immediate
        apply("R7", OP_SLTU,  32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 5'd6);
        apply("R7", OP_SLTIU, 32'h5, 32'h0, 16'hFFFF, 5'd0, 5'd6);
        // R8 fill behaviour
        apply("R8", OP_SRA, 32'h0, 32'h8000_00F0, 16'h0, 5'd4, 5'd7);
        apply("R8", OP_SRL, 32'h0, 32'h8000_00F0, 16'h0, 5'd4, 5'd7);
        apply("R8", OP_SLL, 32'h0, 32'h8000_00F1, 16'h0, 5'd31, 5'd7);
        // R9 variable shift ignores high bits of opa
        apply("R9", OP_SRAV, 32'hFFFF_FFE4, 32'h8000_0000, 16'h0, 5'd0, 5'd8);
        apply("R9", OP_SLLV, 32'h0000_0120, 32'h0000_0001, 16'h0, 5'd7, 5'd8);
        // R10
        apply("R10", OP_NOR, 32'hF0F0_0000, 32'h0000_0F0F, 16'h0, 5'd0, 5'd9);
        // R11 index zero with a clean result
        apply("R11", OP_OR, 32'h1, 32'h2, 16'h0, 5'd0, 5'd0);
        // R12 clean result, nonzero index
        apply("R12", OP_XOR, 32'h1, 32'h3, 16'h0, 5'd0, 5'd31);
        for (int i = 0; i < 2000; i++) begin
            op_e         op;
            logic [31:0] a, b;
            op = op_e'($urandom_range(0, 23));
            a  = $urandom;
            b  = $urandom;
            if ((i % 8) == 0) a = 32'h8000_0000;
            if ((i % 8) == 1) b = 32'h7FFF_FFFF;
            if ((i % 8) == 2) a = 32'hFFFF_FFFF;
            apply(req_of(op), op, a, b, 16'($urandom), 5'($urandom), 5'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule